// File: doc/BRIEF.md
# I2C Register Slave

This block is a serial-bus target for a chip's control plane. A host reaches nine byte-wide registers through a two-wire bus that runs at up to 400 kHz. Registers 00h to 02h are control registers that the host can write. The block holds them and drives them straight out to the logic around it. Registers 03h to 08h are status registers that the host can only read. Their values come from the `statIn` port, one byte per register. The register at 03h takes the least significant byte of `statIn`.

Both bus lines are sampled in the system clock domain. Each line passes through a two-flop synchroniser and then a majority filter, so short spikes on the bus are dropped. The block never drives the bus high. It only asserts `sdaOe`, and the pad logic outside pulls SDA low while that signal is high. A single register pointer serves both writes and reads. It steps forward after every data byte. Once it passes the last register it returns to the first, so writes and reads wrap around the nine-byte window.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave answers only the 7-bit address 0010010. The R/W bit in bit 0 of the address byte selects a read when it is 1 and a write when it is 0, so the write address byte is 24h and the read address byte is 25h. A matching address byte is acknowledged by pulling SDA low during the ninth clock. With any other address, SDA is never driven and no register changes until the next START.
- R2: In a write transfer, the byte after the address byte loads the register pointer from its low 4 bits. The upper bits are ignored, and a value from 9 to 15 selects register 00h. This pointer byte is acknowledged.
- R3: Every data byte in a write transfer is acknowledged and written to the register the pointer selects. The pointer then increments. A control register changes only when such a write reaches it.
- R4: When the pointer steps past 08h it wraps to 00h, on writes and on reads alike. A long page write therefore overwrites the first registers again.
- R5: A read transfer returns the register the pointer selects, most significant bit first. This works right after the address byte (current-address read), and also after a write of the pointer followed by a repeated START and the read address (random read).
- R6: While the master acknowledges each byte read, the next register follows and the pointer increments after every byte sent. After a master NACK the slave releases SDA and drives nothing until the next START.
- R7: Reserved control bits always read 0 and ignore writes. The implemented bits are bits 7:0 of register 00h, bits 5:0 of register 01h and bits 3:0 of register 02h.
- R8: A read of registers 03h to 08h returns the bytes of `statIn`, with 03h taking bits 7:0 and 08h taking bits 47:40. A write to one of them is acknowledged and advances the pointer, but changes no register.
- R9: After reset all control registers are 00h and SDA is released.
- R10: The slave starts pulling SDA low only while SCL is low, and no earlier than HOLD_CYC system clocks after it detects the falling edge of SCL. A START or a STOP releases SDA at once.
- R11: A pulse of two system clocks or less on SCL or SDA (with the default 5-tap filter) is ignored. It creates no clock edge, no START and no STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | High to pull SDA low (open-drain enable) |
| ctrlOut | output | 24 | Control registers 00h..02h, register 00h in bits 7:0 |
| statIn | input | 48 | Status registers 03h..08h, register 03h in bits 7:0 |

## Verification
Four properties are checked on every clock cycle:
- reserved control bits stay at zero;
- the control outputs hold steady unless the controller issues a write strobe;
- the pointer-load, write and read-advance strobes never fire together;
- SDA is only ever pulled low while SCL is low.

Some behaviour only shows up over a whole transfer, so only the bench scenarios can show it: address matching and ignoring other addresses, pointer loading and wraparound, the order of sequential reads, silence after a NACK, the hold delay before the acknowledge, and the rejection of short spikes on each line.

// File: rtl/i2cslv_pkg.sv
package i2cslv_pkg;

  // Strobes from the bus controller to the register datapath
  typedef struct packed {
    logic       ptrLoad;  // load pointer from data
    logic       wrEn;     // write data at pointer, then advance
    logic       rdAdv;    // read byte taken at pointer, then advance
    logic [7:0] data;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } busState_t;

  typedef enum logic [1:0] {
    ROLE_ADDR,
    ROLE_PTR,
    ROLE_WDATA
  } rxRole_t;

endpackage

// File: rtl/i2cslv_regfile.sv
module i2cslv_regfile
  import i2cslv_pkg::*;
#(
  parameter int NCTRL = 3,
  parameter int NSTAT = 6,
  parameter logic [NCTRL*8-1:0] CTRL_MASK = 24'h0F3FFF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [NSTAT*8-1:0]   statIn,
  output logic [NCTRL*8-1:0]   ctrlOut,
  output logic [7:0]           rdByte
);

  localparam int NREG  = NCTRL + NSTAT;
  localparam int PTR_W = $clog2(NREG);

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ldVal;
  logic [PTR_W-1:0] ptrNext;
  logic [7:0]       regView [NREG];

  assign ldVal   = strb.data[PTR_W-1:0];
  assign ptrNext = (int'(ptr) == NREG - 1) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.ptrLoad) begin
      ptr <= (int'(ldVal) >= NREG) ? '0 : ldVal;
    end else if (strb.wrEn || strb.rdAdv) begin
      ptr <= ptrNext;
    end
  end

  // Control registers: reserved bits never stored
  for (genvar i = 0; i < NCTRL; i++) begin : g_ctrl
    logic [7:0] ctrlQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlQ <= '0;
      end else if (strb.wrEn && (ptr == PTR_W'(i))) begin
        ctrlQ <= strb.data & CTRL_MASK[i*8 +: 8];
      end
    end
    assign ctrlOut[i*8 +: 8] = ctrlQ;
    assign regView[i]        = ctrlQ;
  end

  // Status registers: read-only view of the inputs
  for (genvar j = 0; j < NSTAT; j++) begin : g_stat
    assign regView[NCTRL + j] = statIn[j*8 +: 8];
  end

  always_comb begin
    rdByte = '0;
    for (int k = 0; k < NREG; k++) begin
      if (ptr == PTR_W'(k)) rdByte = regView[k];
    end
  end

endmodule

// File: rtl/i2cslv_ctrl.sv
module i2cslv_ctrl
  import i2cslv_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR  = 7'b0010010,
  parameter int         FILT_TAPS = 5,
  parameter int         HOLD_CYC  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  output dpStrobe_t  strb,
  output logic       sdaOe
);

  localparam int HALF = FILT_TAPS / 2;
  localparam int HC_W = $clog2(HOLD_CYC + 1);

  // Synchronise, majority-filter, edge-detect
  logic [1:0]           sclSync, sdaSync;
  logic [FILT_TAPS-1:0] sclHist, sdaHist;
  logic                 sclF, sdaF, sclP, sdaP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclHist <= '1;
      sdaHist <= '1;
      sclF    <= 1'b1;
      sdaF    <= 1'b1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclHist <= {sclHist[FILT_TAPS-2:0], sclSync[1]};
      sdaHist <= {sdaHist[FILT_TAPS-2:0], sdaSync[1]};
      sclF    <= ($countones(sclHist) > HALF);
      sdaF    <= ($countones(sdaHist) > HALF);
      sclP    <= sclF;
      sdaP    <= sdaF;
    end
  end

  logic sclRise, sclFall, startEv, stopEv;
  assign sclRise = sclF & ~sclP;
  assign sclFall = ~sclF & sclP;
  assign startEv = sclF & sclP & sdaP & ~sdaF;
  assign stopEv  = sclF & sclP & ~sdaP & sdaF;

  // Byte-level state machine
  busState_t  st;
  rxRole_t    role;
  logic [3:0] bitCnt;
  logic [7:0] shReg;
  logic       isRead;
  logic       mAckd;
  logic       byteDone;
  logic       addrHit;

  assign byteDone = (st == ST_RX) && sclFall && (bitCnt == 4'd8);
  assign addrHit  = (shReg[7:1] == SLV_ADDR);

  always_comb begin
    strb = '0;
    strb.data = shReg;
    if (!startEv && !stopEv) begin
      if (byteDone && role == ROLE_PTR)   strb.ptrLoad = 1'b1;
      if (byteDone && role == ROLE_WDATA) strb.wrEn    = 1'b1;
      if (sclFall && ((st == ST_RXACK && isRead) || (st == ST_TXACK && mAckd)))
        strb.rdAdv = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      role   <= ROLE_ADDR;
      bitCnt <= '0;
      shReg  <= '0;
      isRead <= 1'b0;
      mAckd  <= 1'b0;
    end else if (startEv) begin
      st     <= ST_RX;
      role   <= ROLE_ADDR;
      bitCnt <= '0;
      isRead <= 1'b0;
    end else if (stopEv) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_RX: begin
          if (sclRise) begin
            shReg  <= {shReg[6:0], sdaF};
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            bitCnt <= '0;
            unique case (role)
              ROLE_ADDR: begin
                if (addrHit) begin
                  st     <= ST_RXACK;
                  isRead <= shReg[0];
                  role   <= ROLE_PTR;
                end else begin
                  st <= ST_IDLE;
                end
              end
              ROLE_PTR: begin
                st   <= ST_RXACK;
                role <= ROLE_WDATA;
              end
              default: st <= ST_RXACK;
            endcase
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            if (isRead) begin
              st     <= ST_TX;
              shReg  <= rdByte;
              bitCnt <= '0;
            end else begin
              st <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              st <= ST_TXACK;
            end else begin
              shReg  <= {shReg[6:0], 1'b0};
              bitCnt <= bitCnt + 4'd1;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            mAckd <= ~sdaF;
          end else if (sclFall) begin
            if (mAckd) begin
              st     <= ST_TX;
              shReg  <= rdByte;
              bitCnt <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // SDA driver: update a fixed delay after each SCL fall
  logic            driveReq;
  logic [HC_W-1:0] holdCnt;

  assign driveReq = (st == ST_RXACK) || ((st == ST_TX) && !shReg[7]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      sdaOe   <= 1'b0;
    end else begin
      if (sclFall)               holdCnt <= HC_W'(HOLD_CYC);
      else if (holdCnt != '0)    holdCnt <= holdCnt - 1'b1;
      if (startEv || stopEv)          sdaOe <= 1'b0;
      else if (holdCnt == HC_W'(1))   sdaOe <= driveReq;
    end
  end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2cslv_pkg::*;
#(
  parameter logic [6:0]          SLV_ADDR  = 7'b0010010,
  parameter int                  NCTRL     = 3,
  parameter int                  NSTAT     = 6,
  parameter logic [NCTRL*8-1:0]  CTRL_MASK = 24'h0F3FFF,
  parameter int                  FILT_TAPS = 5,
  parameter int                  HOLD_CYC  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  output logic [NCTRL*8-1:0] ctrlOut,
  input  logic [NSTAT*8-1:0] statIn
);

  dpStrobe_t  strb;
  logic [7:0] rdByte;

  i2cslv_ctrl #(
    .SLV_ADDR (SLV_ADDR),
    .FILT_TAPS(FILT_TAPS),
    .HOLD_CYC (HOLD_CYC)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .rdByte(rdByte),
    .strb  (strb),
    .sdaOe (sdaOe)
  );

  i2cslv_regfile #(
    .NCTRL    (NCTRL),
    .NSTAT    (NSTAT),
    .CTRL_MASK(CTRL_MASK)
  ) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .statIn (statIn),
    .ctrlOut(ctrlOut),
    .rdByte (rdByte)
  );

endmodule

// File: rtl/i2cslv_chk.sv
module i2cslv_chk
  import i2cslv_pkg::*;
#(
  parameter int                 NCTRL     = 3,
  parameter logic [NCTRL*8-1:0] CTRL_MASK = 24'h0F3FFF
) (
  input logic               clk,
  input logic               rstN,
  input logic               sclIn,
  input logic               sdaOe,
  input logic [NCTRL*8-1:0] ctrlOut,
  input dpStrobe_t          strb
);

  // R7: reserved control bits never become 1
  p_rsv_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut & ~CTRL_MASK) == '0);

  // R3: control registers move only in response to a write strobe
  p_hold_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(ctrlOut));

  // R3: pointer load, write and read advance never coincide
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ptrLoad, strb.wrEn, strb.rdAdv}));

  // R10: SDA pull-down begins only while SCL is low
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

endmodule

bind i2c_reg_slave i2cslv_chk #(
  .NCTRL    (NCTRL),
  .CTRL_MASK(CTRL_MASK)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .sclIn  (sclIn),
  .sdaOe  (sdaOe),
  .ctrlOut(ctrlOut),
  .strb   (strb)
);

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;

  localparam int Q        = 40;
  localparam int HOLD     = 4;
  localparam logic [47:0] STAT = 48'h9C_81_E7_5A_3C_C5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaOe;
  logic [23:0] ctrlOut;

  always #2 clk = ~clk;  // 250 MHz

  assign sdaLine = sdaM & ~sdaOe;

  i2c_reg_slave u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclM),
    .sdaIn  (sdaLine),
    .sdaOe  (sdaOe),
    .ctrlOut(ctrlOut),
    .statIn (STAT)
  );

  int total = 0;
  int bad = 0;
  bit busy = 1'b1;
  bit finished = 1'b0;

  // behavioural model
  int ctrlM[3] = '{0, 0, 0};
  int maskM[3] = '{8'hFF, 8'h3F, 8'h0F};
  int ptrM = 0;

  function automatic logic [23:0] modelCtrl();
    return {ctrlM[2][7:0], ctrlM[1][7:0], ctrlM[0][7:0]};
  endfunction

  function automatic int regVal(int idx);
    if (idx < 3) return ctrlM[idx];
    return int'(STAT[(idx-3)*8 +: 8]);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  // control outputs compared against the model on every idle clock
  always @(negedge clk) begin
    if (rstN && !busy && !finished)
      chk(ctrlOut == modelCtrl(), "R3 ctrlOut vs model", int'(ctrlOut), int'(modelCtrl()));
  end

  task automatic i2cStart();
    sdaM = 1'b1; waitN(Q);
    sclM = 1'b1; waitN(Q);
    sdaM = 1'b0; waitN(Q);
    sclM = 1'b0;
  endtask

  task automatic i2cStop();
    waitN(4); sdaM = 1'b0; waitN(Q);
    sclM = 1'b1; waitN(Q);
    sdaM = 1'b1; waitN(Q);
  endtask

  // glitch: 0 none, 1 SCL dip, 2 SDA flip (R11)
  task automatic sendBit(bit b, int glitch);
    waitN(4); sdaM = b; waitN(Q - 4);
    sclM = 1'b1; waitN(Q);
    if (glitch == 1) begin sclM = 1'b0; waitN(2); sclM = 1'b1; end
    if (glitch == 2) begin sdaM = ~b;   waitN(2); sdaM = b;    end
    waitN(Q);
    sclM = 1'b0;
  endtask

  task automatic sendByte(int b, bit expAck, string tag, int glitch = 0);
    int firstDrive = -1;
    for (int i = 7; i >= 0; i--) sendBit(b[i], (i == 3) ? glitch : 0);
    for (int i = 0; i < Q; i++) begin
      @(negedge clk);
      if (i == 3) sdaM = 1'b1;
      if (sdaOe && firstDrive < 0) firstDrive = i + 1;
    end
    if (expAck)
      chk(firstDrive >= HOLD && firstDrive < Q, {tag, " R10 ack delay"}, firstDrive, HOLD);
    sclM = 1'b1; waitN(Q);
    chk(sdaOe == expAck, {tag, " ack"}, int'(sdaOe), int'(expAck));
    waitN(Q);
    sclM = 1'b0;
  endtask

  task automatic readByte(int exp, bit mAck, string tag);
    for (int i = 7; i >= 0; i--) begin
      waitN(Q); sclM = 1'b1; waitN(Q);
      chk(sdaLine == exp[i], tag, int'(sdaLine), exp[i]);
      waitN(Q); sclM = 1'b0;
    end
    waitN(4); sdaM = ~mAck; waitN(Q - 4);
    sclM = 1'b1; waitN(Q);
    chk(sdaOe == 1'b0, {tag, " R6 released in ack slot"}, int'(sdaOe), 0);
    waitN(Q); sclM = 1'b0;
    waitN(4); sdaM = 1'b1;
  endtask

  task automatic doWrite(int ptrByte, int data[$], string tag, int glitch = 0);
    busy = 1'b1;
    i2cStart();
    sendByte(8'h24, 1'b1, {tag, " R1 addr"});
    sendByte(ptrByte, 1'b1, {tag, " R2 ptr"});
    ptrM = ptrByte & 15;
    if (ptrM > 8) ptrM = 0;
    foreach (data[k]) begin
      sendByte(data[k], 1'b1, {tag, " R3 data"}, (k == 0) ? glitch : 0);
      if (ptrM < 3) ctrlM[ptrM] = data[k] & maskM[ptrM];
      ptrM = (ptrM + 1) % 9;
    end
    i2cStop();
    waitN(8);
    chk(ctrlOut == modelCtrl(), {tag, " ctrlOut"}, int'(ctrlOut), int'(modelCtrl()));
    busy = 1'b0;
  endtask

  // read n bytes; optional pointer set with repeated START
  task automatic doRead(int ptrByte, int n, string tag);
    busy = 1'b1;
    i2cStart();
    if (ptrByte >= 0) begin
      sendByte(8'h24, 1'b1, {tag, " R1 addr"});
      sendByte(ptrByte, 1'b1, {tag, " R2 ptr"});
      ptrM = ptrByte & 15;
      if (ptrM > 8) ptrM = 0;
      i2cStart();
    end
    sendByte(8'h25, 1'b1, {tag, " R1 read addr"});
    for (int k = 0; k < n; k++) begin
      readByte(regVal(ptrM), k != n - 1, {tag, " R5 data"});
      ptrM = (ptrM + 1) % 9;
    end
    busy = 1'b0;
  endtask

  initial begin
    waitN(10);
    chk(sdaOe == 1'b0, "R9 sdaOe in reset", int'(sdaOe), 0);
    rstN = 1'b1;
    waitN(4);
    chk(ctrlOut == 24'h0, "R9 ctrl reset", int'(ctrlOut), 0);
    chk(sdaOe == 1'b0, "R9 sdaOe after reset", int'(sdaOe), 0);
    busy = 1'b0;

    // R7: reserved bits of register 01h
    doWrite(8'h01, '{8'hFF}, "R7 byte write");
    // R3: page write across the control registers
    doWrite(8'h00, '{8'hA5, 8'hC3, 8'hFF}, "R3 page write");
    // R4/R8: status writes ignored, then wrap to 00h
    doWrite(8'h07, '{8'h11, 8'h22, 8'h5E, 8'h77}, "R4 R8 wrap write");

    // R5/R8/R4: random read through status and wrap
    doRead(8'h04, 7, "R4 R8 random read");
    busy = 1'b1;
    // R6: after NACK the slave stays silent
    readByte(8'hFF, 1'b0, "R6 silent after nack");
    i2cStop();
    busy = 1'b0;

    // R5: current-address read continues at pointer
    doRead(-1, 1, "R5 current read");
    busy = 1'b1;
    i2cStop();

    // R1: foreign addresses ignored
    i2cStart();
    sendByte(8'h26, 1'b0, "R1 wrong addr");
    sendByte(8'h00, 1'b0, "R1 ignored ptr");
    sendByte(8'h99, 1'b0, "R1 ignored data");
    i2cStop();
    i2cStart();
    sendByte(8'h27, 1'b0, "R1 wrong read addr");
    readByte(8'hFF, 1'b0, "R1 no read data");
    i2cStop();
    waitN(8);
    chk(ctrlOut == modelCtrl(), "R1 ctrl untouched", int'(ctrlOut), int'(modelCtrl()));
    busy = 1'b0;

    // R2: out-of-range pointer selects 00h
    doWrite(8'h0B, '{8'h44}, "R2 ptr high");
    // R11: spikes on SCL and on SDA
    doWrite(8'h02, '{8'h06}, "R11 scl spike", 1);
    doWrite(8'h01, '{8'h2A}, "R11 sda spike", 2);

    // read back all control registers
    doRead(8'h00, 3, "R5 readback");
    busy = 1'b1;
    i2cStop();
    busy = 1'b0;
    waitN(20);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule